// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block sits on the receive byte stream of an Ethernet MAC and raises a wake request when a frame carries the magic wake pattern. The pattern is a run of at least six 0xFF bytes followed directly by sixteen unbroken copies of the station's 48-bit address. It may start anywhere in the frame after the two leading 6-byte address fields, and those twelve header bytes never count towards a match. The flag is raised only if the frame closes with a good CRC, is not a runt and was not cut off by a new start-of-frame.

Detection is armed in two ways. In the full-power state a software enable bit arms it. In the light-sleep state it is armed whatever that bit holds. In the two deeper states it stays off. While detection is off, every piece of partial-match state is held cleared. The wake flag is sticky and only a clear pulse brings it back to zero.

Top module: `magic_wake_det`

## Requirements
- R1: After reset `wake_flag` is 0.
- R2: A frame that carries the sync run and the sixteen address copies, and that ends with `rx_eof` and `rx_good` high, sets `wake_flag` on the clock edge after the `rx_eof` cycle and not earlier.
- R3: The first twelve bytes of a frame (the byte with `rx_sof` is byte 0) are never matched, so 0xFF bytes in the header do not count towards the sync run.
- R4: A sync run of six or more 0xFF bytes is accepted. A run of five is not.
- R5: A byte that breaks the sequence restarts the search. If that byte is 0xFF it counts as the first byte of a new sync run.
- R6: Address bytes are compared in transmission order, `station_addr[47:40]` first. Fifteen copies, or copies with the octets reversed, do not match.
- R7: A frame ended with `rx_good` low never sets `wake_flag`.
- R8: A frame of fewer than `MIN_FRAME_BYTES` bytes (default 64, counting every `rx_valid` byte from `rx_sof` up to `rx_eof`) never sets `wake_flag`. A frame of exactly that length can set it.
- R9: An `rx_sof` byte that arrives before the current frame's `rx_eof` aborts that frame. Its partial match is discarded and never sets `wake_flag`.
- R10: Detection is armed when `pwr_state` is 0 (full power) and `mp_enable` is 1, or when `pwr_state` is 1 (light sleep) whatever `mp_enable` holds. It is never armed for `pwr_state` 2 or 3.
- R11: While disarmed, the match state is cleared, so a partial match made before a disarmed cycle cannot complete after it.
- R12: `wake_flag` stays 1 until `wake_clr` is pulsed. A qualifying `rx_eof` in the same cycle as `wake_clr` wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present on `rx_data` |
| rx_sof | input | 1 | With `rx_valid`: this byte is the first byte of a frame |
| rx_eof | input | 1 | End-of-frame strobe on a cycle of its own. No byte is taken in this cycle |
| rx_good | input | 1 | With `rx_eof`: the frame CRC checked good |
| rx_data | input | 8 | Receive byte |
| station_addr | input | 48 | Station address, first transmitted octet in bits 47:40 |
| mp_enable | input | 1 | Software enable for detection in the full-power state |
| pwr_state | input | 2 | 0 full power, 1 light sleep, 2 and 3 deeper sleep |
| wake_clr | input | 1 | Clears `wake_flag` |
| wake_flag | output | 1 | Sticky wake request |

## Verification
Directed frames place the pattern at the header boundary, stretch or shorten the sync run, and break the address run with a 0xFF byte or with another byte. This shows whether the matcher restarts with the right sync count and skips the header. Further directed frames sit just below, at and above the minimum length, end with a bad CRC, get aborted by an early start-of-frame, or arrive with the arming inputs in each power state or dropped in the middle of the pattern. These cases separate the frame-qualification logic from the pattern search. Random frames with biased 0xFF content, partial sync runs, short repeat counts and single corrupted bytes are compared against a byte-level model of the search. They catch ordering mistakes in the counter updates that the directed cases miss.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  localparam int unsigned OCTET_W    = 8;
  localparam int unsigned MAC_OCTETS = 6;
  localparam int unsigned HDR_OCTETS = 2 * MAC_OCTETS;
  localparam logic [OCTET_W-1:0] SYNC_OCTET = 8'hFF;

  typedef enum logic [1:0] {
    PWR_FULL  = 2'd0,
    PWR_LIGHT = 2'd1,
    PWR_DEEP  = 2'd2,
    PWR_OFF   = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_ADDR = 2'd1,
    PH_DONE = 2'd2
  } match_phase_e;

endpackage

// File: rtl/mwd_rst_sync.sv
module mwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/mwd_arm_ctrl.sv
module mwd_arm_ctrl
  import mwd_pkg::*;
(
  input  logic [1:0] pwr_state,
  input  logic       mp_enable,
  output logic       armed
);

  pwr_state_e pwr;

  always_comb begin
    pwr = pwr_state_e'(pwr_state);
    unique case (pwr)
      PWR_FULL:  armed = mp_enable;
      PWR_LIGHT: armed = 1'b1;
      default:   armed = 1'b0;
    endcase
  end

endmodule

// File: rtl/mwd_frame_track.sv
module mwd_frame_track #(
  parameter int unsigned MIN_FRAME_BYTES = 64,
  parameter int unsigned HDR_BYTES       = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_sof,
  input  logic rx_eof,
  input  logic rx_good,
  output logic frame_start,
  output logic payload_vld,
  output logic len_ok,
  output logic frame_good_end
);

  localparam int unsigned CNT_MAX = (MIN_FRAME_BYTES > HDR_BYTES) ? MIN_FRAME_BYTES : HDR_BYTES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_FRAME_BYTES);

  logic             in_frame_q, in_frame_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             byte_in;
  logic             upd_en;

  always_comb begin
    frame_start    = rx_valid & rx_sof;
    byte_in        = rx_valid & ~rx_sof & ~rx_eof & in_frame_q;
    payload_vld    = byte_in & (cnt_q >= HDR_C);
    len_ok         = (cnt_q >= MIN_C);
    frame_good_end = rx_eof & in_frame_q & rx_good & len_ok;
  end

  always_comb begin
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    upd_en     = 1'b0;
    if (frame_start) begin
      in_frame_d = 1'b1;
      cnt_d      = CNT_W'(1);
      upd_en     = 1'b1;
    end else if (rx_eof) begin
      in_frame_d = 1'b0;
      cnt_d      = '0;
      upd_en     = 1'b1;
    end else if (byte_in && (cnt_q != CNT_TOP)) begin
      cnt_d      = cnt_q + CNT_W'(1);
      upd_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (upd_en) begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
    end
  end

endmodule

// File: rtl/mwd_magic_match.sv
module mwd_magic_match
  import mwd_pkg::*;
#(
  parameter int unsigned SYNC_LEN     = 6,
  parameter int unsigned ADDR_REPEATS = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            armed,
  input  logic                            frame_start,
  input  logic                            payload_vld,
  input  logic [OCTET_W-1:0]              pay_byte,
  input  logic [MAC_OCTETS*OCTET_W-1:0]   station_addr,
  output logic                            found
);

  localparam int unsigned SYNC_W = $clog2(SYNC_LEN + 1);
  localparam int unsigned IDX_W  = $clog2(MAC_OCTETS);
  localparam int unsigned REP_W  = (ADDR_REPEATS > 1) ? $clog2(ADDR_REPEATS) : 1;
  localparam logic [SYNC_W-1:0] SYNC_FULL = SYNC_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(MAC_OCTETS - 1);
  localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(ADDR_REPEATS - 1);

  logic [MAC_OCTETS-1:0][OCTET_W-1:0] oct;

  // Octets in the order they appear on the wire.
  for (genvar g = 0; g < MAC_OCTETS; g++) begin : g_oct
    assign oct[g] = station_addr[(MAC_OCTETS-1-g)*OCTET_W +: OCTET_W];
  end

  match_phase_e      phase_q, phase_d;
  logic [SYNC_W-1:0] ff_q, ff_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [OCTET_W-1:0] exp_oct;
  logic              addr_hit;
  logic              is_sync;
  logic              upd_en;

  always_comb begin
    exp_oct = '0;
    for (int i = 0; i < MAC_OCTETS; i++) begin
      if (idx_q == IDX_W'(i)) exp_oct = oct[i];
    end
    addr_hit = (pay_byte == exp_oct);
    is_sync  = (pay_byte == SYNC_OCTET);
  end

  always_comb begin
    phase_d = phase_q;
    ff_d    = ff_q;
    idx_d   = idx_q;
    rep_d   = rep_q;
    upd_en  = 1'b0;
    if (!armed || frame_start) begin
      phase_d = PH_SYNC;
      ff_d    = '0;
      idx_d   = '0;
      rep_d   = '0;
      upd_en  = 1'b1;
    end else if (payload_vld) begin
      upd_en = 1'b1;
      unique case (phase_q)
        PH_SYNC: begin
          if ((ff_q == SYNC_FULL) && addr_hit) begin
            phase_d = PH_ADDR;
            ff_d    = '0;
            idx_d   = IDX_W'(1);
            rep_d   = '0;
          end else if (is_sync) begin
            if (ff_q != SYNC_FULL) ff_d = ff_q + SYNC_W'(1);
          end else begin
            ff_d = '0;
          end
        end
        PH_ADDR: begin
          if (addr_hit) begin
            if (idx_q == IDX_LAST) begin
              idx_d = '0;
              if (rep_q == REP_LAST) phase_d = PH_DONE;
              else                   rep_d   = rep_q + REP_W'(1);
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end else begin
            phase_d = PH_SYNC;
            idx_d   = '0;
            rep_d   = '0;
            ff_d    = is_sync ? SYNC_W'(1) : '0;
          end
        end
        PH_DONE: begin
          phase_d = PH_DONE;
        end
        default: begin
          phase_d = PH_SYNC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SYNC;
      ff_q    <= '0;
      idx_q   <= '0;
      rep_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      ff_q    <= ff_d;
      idx_q   <= idx_d;
      rep_q   <= rep_d;
    end
  end

  assign found = (phase_q == PH_DONE);

endmodule

// File: rtl/magic_wake_det.sv
module magic_wake_det
  import mwd_pkg::*;
#(
  parameter int unsigned MIN_FRAME_BYTES = 64,
  parameter int unsigned SYNC_LEN        = 6,
  parameter int unsigned ADDR_REPEATS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic [7:0]  rx_data,
  input  logic [47:0] station_addr,
  input  logic        mp_enable,
  input  logic [1:0]  pwr_state,
  input  logic        wake_clr,
  output logic        wake_flag
);

  logic rst_n_int;
  logic det_armed;
  logic frame_start;
  logic payload_vld;
  logic frame_len_ok;
  logic frame_good_end;
  logic match_found;
  logic wake_q, wake_d, wake_en, wake_set;

  mwd_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mwd_arm_ctrl arm_i (
    .pwr_state (pwr_state),
    .mp_enable (mp_enable),
    .armed     (det_armed)
  );

  mwd_frame_track #(
    .MIN_FRAME_BYTES (MIN_FRAME_BYTES),
    .HDR_BYTES       (HDR_OCTETS)
  ) track_i (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .rx_valid       (rx_valid),
    .rx_sof         (rx_sof),
    .rx_eof         (rx_eof),
    .rx_good        (rx_good),
    .frame_start    (frame_start),
    .payload_vld    (payload_vld),
    .len_ok         (frame_len_ok),
    .frame_good_end (frame_good_end)
  );

  mwd_magic_match #(
    .SYNC_LEN     (SYNC_LEN),
    .ADDR_REPEATS (ADDR_REPEATS)
  ) match_i (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .armed        (det_armed),
    .frame_start  (frame_start),
    .payload_vld  (payload_vld),
    .pay_byte     (rx_data),
    .station_addr (station_addr),
    .found        (match_found)
  );

  // Set beats clear so a wake event in the clearing cycle is kept.
  always_comb begin
    wake_set = frame_good_end & match_found & det_armed;
    wake_en  = wake_set | wake_clr;
    wake_d   = wake_set;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      wake_q <= 1'b0;
    end else if (wake_en) begin
      wake_q <= wake_d;
    end
  end

  assign wake_flag = wake_q;

endmodule

// File: rtl/mwd_magic_chk.sv
module mwd_magic_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_eof,
  input logic       rx_good,
  input logic       mp_enable,
  input logic [1:0] pwr_state,
  input logic       wake_clr,
  input logic       wake_flag,
  input logic       len_ok,
  input logic       armed,
  input logic       found
);

  p_set_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(rx_eof));

  p_good_crc_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(rx_good));

  p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(len_ok));

  p_arming_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past((pwr_state == 2'd0 && mp_enable) || pwr_state == 2'd1));

  p_disarm_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !found);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !wake_clr) |=> wake_flag);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !rx_eof) |=> !wake_flag);

endmodule

bind magic_wake_det mwd_magic_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_eof    (rx_eof),
  .rx_good   (rx_good),
  .mp_enable (mp_enable),
  .pwr_state (pwr_state),
  .wake_clr  (wake_clr),
  .wake_flag (wake_flag),
  .len_ok    (frame_len_ok),
  .armed     (det_armed),
  .found     (match_found)
);

// File: tb/magic_wake_det_tb_top.sv
module magic_wake_det_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BENCH_MIN  = 128;

  logic        clk;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_good;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic        mp_enable;
  logic [1:0]  pwr_state;
  logic        wake_clr;
  logic        wake_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] frm [$];

  magic_wake_det #(.MIN_FRAME_BYTES(BENCH_MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_good(rx_good), .rx_data(rx_data),
    .station_addr(station_addr), .mp_enable(mp_enable),
    .pwr_state(pwr_state), .wake_clr(wake_clr), .wake_flag(wake_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] oct_of(input logic [47:0] a, input int k);
    return a[47-8*k -: 8];
  endfunction

  // Byte-level model of the search, built from R3 to R6.
  function automatic bit model_found(input logic [47:0] a);
    int ff = 0, ph = 0, idx = 0, rep = 0;
    for (int i = 12; i < frm.size(); i++) begin
      logic [7:0] b = frm[i];
      if (ph == 0) begin
        if (ff == 6 && b == oct_of(a, 0)) begin ph = 1; idx = 1; rep = 0; end
        else if (b == 8'hFF) begin if (ff < 6) ff++; end
        else ff = 0;
      end else if (ph == 1) begin
        if (b == oct_of(a, idx)) begin
          if (idx == 5) begin
            idx = 0;
            if (rep == 15) ph = 2; else rep++;
          end else idx++;
        end else begin
          ph = 0; idx = 0; rep = 0; ff = (b == 8'hFF) ? 1 : 0;
        end
      end
    end
    return ph == 2;
  endfunction

  task automatic push_rand(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'($urandom));
  endtask
  task automatic push_hdr();
    for (int i = 0; i < 12; i++) frm.push_back(8'($urandom) & 8'h7F);
  endtask
  task automatic push_sync(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hFF);
  endtask
  task automatic push_addr(input int reps, input logic [47:0] a);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 6; k++) frm.push_back(oct_of(a, k));
  endtask
  task automatic push_pad(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'h5A);
  endtask

  task automatic clear_flag();
    @(negedge clk); wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
  endtask

  // Sends frm. gap_at >= 0 inserts one idle, disarmed cycle before that byte.
  task automatic send(input bit do_eof, input bit good, input int gap_at, input bit clr_eof);
    for (int i = 0; i < frm.size(); i++) begin
      if (i == gap_at) begin
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; mp_enable = 1'b0;
        @(negedge clk); mp_enable = 1'b1;
      end else begin
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = frm[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    if (do_eof) begin
      rx_eof = 1'b1; rx_good = good; wake_clr = clr_eof;
      @(negedge clk);
      rx_eof = 1'b0; rx_good = 1'b0; wake_clr = 1'b0;
    end
  endtask

  task automatic run(input string req, input string what, input bit good, input bit exp);
    clear_flag();
    send(1'b1, good, -1, 1'b0);
    chk(req, what, wake_flag, exp);
    frm.delete();
  endtask

  initial begin
    logic [47:0] A;
    int unsigned seed;
    seed = $urandom(32'h0000_C0DE);
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = '0;
    A = 48'h02_1B_3C_4D_5E_6F;
    station_addr = A; mp_enable = 1'b1; pwr_state = 2'd0; wake_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "flag after reset", wake_flag, 1'b0);

    // R2 basic, and no early set at the eof cycle
    clear_flag();
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = (i == 0); rx_data = frm[i];
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 1; rx_good = 1;
    chk("R2", "flag not yet set in eof cycle", wake_flag, 1'b0);
    @(negedge clk); rx_eof = 0; rx_good = 0;
    chk("R2", "basic magic frame", wake_flag, 1'b1);
    frm.delete();

    // R3 sync inside header does not count
    for (int i = 0; i < 6; i++) frm.push_back(8'h11);
    push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R3", "sync run inside header", 1'b1, 1'b0);

    // R4
    push_hdr(); push_sync(9); push_addr(16, A); push_pad(20); push_rand(4);
    run("R4", "long sync run", 1'b1, 1'b1);
    push_hdr(); push_sync(5); push_addr(16, A); push_pad(20); push_rand(4);
    run("R4", "five-byte sync run", 1'b1, 1'b0);

    // R5
    push_hdr(); push_sync(6); push_addr(7, A); push_sync(6); push_addr(16, A); push_pad(10); push_rand(4);
    run("R5", "0xFF breaker starts new sync", 1'b1, 1'b1);
    push_hdr(); push_sync(6); push_addr(3, A); push_sync(5); push_addr(16, A); push_pad(10); push_rand(4);
    run("R5", "breaker plus four 0xFF is too short", 1'b1, 1'b0);
    push_hdr(); push_sync(6); push_addr(3, A); frm.push_back(8'h00); push_addr(16, A); push_pad(10); push_rand(4);
    run("R5", "non-0xFF breaker needs new sync", 1'b1, 1'b0);

    // R6
    push_hdr(); push_sync(6); push_addr(15, A); push_pad(30); push_rand(4);
    run("R6", "fifteen copies", 1'b1, 1'b0);
    push_hdr(); push_sync(6); push_addr(16, {<<8{A}}); push_pad(20); push_rand(4);
    run("R6", "reversed octet order", 1'b1, 1'b0);

    // R7
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R7", "bad CRC", 1'b0, 1'b0);

    // R8 boundaries around BENCH_MIN (pattern frame body is 118 bytes)
    push_hdr(); push_sync(6); push_addr(16, A); push_rand(4);
    run("R8", "runt 118 bytes", 1'b1, 1'b0);
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(9); push_rand(4);
    run("R8", "length min-1", 1'b1, 1'b0);
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(10); push_rand(4);
    run("R8", "length exactly min", 1'b1, 1'b1);

    // R9 abort: full pattern, no eof, then a plain good frame
    clear_flag();
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20);
    send(1'b0, 1'b0, -1, 1'b0);
    frm.delete();
    push_hdr(); push_pad(130);
    send(1'b1, 1'b1, -1, 1'b0);
    chk("R9", "aborted pattern frame", wake_flag, 1'b0);
    frm.delete();
    // R9 partial pattern must not continue into next frame
    clear_flag();
    push_hdr(); push_sync(6); push_addr(8, A);
    send(1'b0, 1'b0, -1, 1'b0);
    frm.delete();
    push_hdr(); push_addr(8, A); push_pad(40); push_rand(4);
    send(1'b1, 1'b1, -1, 1'b0);
    chk("R9", "partial match across abort", wake_flag, 1'b0);
    frm.delete();

    // R10
    mp_enable = 1'b0; pwr_state = 2'd1;
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R10", "light sleep, enable low", 1'b1, 1'b1);
    pwr_state = 2'd0;
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R10", "full power, enable low", 1'b1, 1'b0);
    mp_enable = 1'b1; pwr_state = 2'd2;
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R10", "deep sleep", 1'b1, 1'b0);
    pwr_state = 2'd3;
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R10", "off state", 1'b1, 1'b0);
    pwr_state = 2'd0;

    // R11 disarm for one idle cycle in the middle of the address run
    clear_flag();
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    send(1'b1, 1'b1, 12 + 6 + 40, 1'b0);
    chk("R11", "disarm mid-pattern", wake_flag, 1'b0);
    frm.delete();

    // R12 sticky, clear, set wins over clear
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    run("R12", "set before sticky check", 1'b1, 1'b1);
    repeat (7) @(negedge clk);
    chk("R12", "flag held while idle", wake_flag, 1'b1);
    push_hdr(); push_pad(130);
    send(1'b1, 1'b1, -1, 1'b0);
    chk("R12", "flag held over plain frame", wake_flag, 1'b1);
    frm.delete();
    clear_flag();
    chk("R12", "clear pulse", wake_flag, 1'b0);
    push_hdr(); push_sync(6); push_addr(16, A); push_pad(20); push_rand(4);
    send(1'b1, 1'b1, -1, 1'b1);
    chk("R12", "set wins over clear", wake_flag, 1'b1);
    frm.delete();

    // Random frames against the model (R2 R4 R5 R6 R7 R8)
    for (int t = 0; t < 250; t++) begin
      bit good, expw;
      logic [47:0] ra;
      ra = {8'($urandom) & 8'hFC, 8'($urandom), 32'($urandom)};
      station_addr = ra;
      push_hdr();
      for (int i = 0; i < int'($urandom % 16); i++)
        frm.push_back(($urandom % 2) ? 8'hFF : 8'($urandom));
      if ($urandom % 3 != 0) begin
        push_sync(4 + int'($urandom % 5));
        push_addr(14 + int'($urandom % 3), ra);
      end
      if ($urandom % 4 == 0) begin
        int p = 12 + int'($urandom % (frm.size() - 12 + 1));
        if (p < frm.size()) frm[p] = 8'($urandom);
      end
      push_rand(int'($urandom % 30));
      push_rand(4);
      good = ($urandom % 5) != 0;
      expw = model_found(ra) && good && (frm.size() >= BENCH_MIN);
      run("R2", $sformatf("random frame %0d", t), good, expw);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule